// File: doc/BRIEF.md
# Colour Lookup Table Loader with Sequenced Component Port

The block holds a 256-entry colour lookup table with 24-bit RGB entries. It is loaded through a small 32-bit register window with byte offsets. Software first writes a starting entry number to the index register. It then writes colour components to the data register. Each data write delivers one 8-bit component, carried in the most significant byte of the bus word. Components arrive as red, then green, then blue, so three writes fill one entry. After the blue write the block moves on to the next entry by itself, and a whole palette can be streamed through one address. Every read of the window returns zero.

A second port serves the display pipeline. It presents an entry number and gets that entry's 24-bit colour back in the same cycle. Each time a component is stored, the block raises a one-cycle notification that downstream logic can use to schedule a screen refresh.

Top module: `clut_loader`

## Requirements
- R1: After reset, every entry reads 0x000000 on the lookup port except entry 255, which reads 0xFFFFFF. The internal entry number and component position are cleared, so the first data write goes to the red component of entry 0.
- R2: A write to byte offset 0x0 loads the entry number from bus data bits 31:24. The next data write goes to red.
- R3: Writes to byte offset 0x4 store bus data bits 31:24 into one component of the current entry, taking red, green and blue in turn. On the lookup port red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R4: After a blue write the entry number increments by one, wrapping from 255 to 0, and the component position returns to red.
- R5: Every read transfer (valid high, write low) returns zero on the read-data output and changes neither the table, the entry number nor the component position.
- R6: Writes to any offset other than 0x0 and 0x4 (offsets 0x1 to 0x3 and 0x5 to 0xF) have no effect.
- R7: The lookup output is combinational from the lookup index. A stored component is visible from the cycle after its write, and a lookup of the entry being written in the same cycle returns the old value.
- R8: The output entry_changed is high for exactly the one cycle that follows each data-port write, and is low in every other cycle.
- R9: A write to the index register partway through a triple abandons that triple. The partially written entry keeps the components already stored, and the next data write goes to red of the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Transfer strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data; the useful byte is bits 31:24 |
| bus_rdata | output | 32 | Read data, always zero |
| lk_index | input | 8 | Lookup entry number from the display pipeline |
| lk_rgb | output | 24 | Colour of the entry at lk_index {R,G,B} |
| entry_changed | output | 1 | One-cycle pulse after each component store |

## Verification
The hardest state to reach is a lookup of the entry being written in the same cycle the component lands, especially when that entry is at the wrap boundary from 255 to 0. A directed sequence covers this. It parks the lookup index on the target entry, writes a triple across entry 255, and compares the old and new colours on either side of the clock edge. A second directed case re-targets the index midway through a triple. A long random phase then interleaves writes to every offset, reads, and arbitrary lookups, while a behavioural model tracks the expected table each cycle.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  function automatic phase_e phase_after(input phase_e cur);
    case (cur)
      PH_RED:  phase_after = PH_GRN;
      PH_GRN:  phase_after = PH_BLU;
      default: phase_after = PH_RED;
    endcase
  endfunction

  function automatic logic [2:0] phase_onehot(input phase_e cur);
    case (cur)
      PH_RED:  phase_onehot = 3'b001;
      PH_GRN:  phase_onehot = 3'b010;
      PH_BLU:  phase_onehot = 3'b100;
      default: phase_onehot = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/clut_decode.sv
module clut_decode #(
  parameter int ADDR_W   = 4,
  parameter int IDX_OFS  = 0,
  parameter int DATA_OFS = 4
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              idx_wr,
  output logic              data_wr
);
  localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(IDX_OFS);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

  logic wr_any;
  assign wr_any  = bus_valid & bus_write;
  assign idx_wr  = wr_any & (bus_addr == IDX_A);
  assign data_wr = wr_any & (bus_addr == DATA_A);
endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic             data_wr,
  input  logic [IDX_W-1:0] new_idx,
  output logic [IDX_W-1:0] idx,
  output phase_e           phase,
  output logic [2:0]       comp_we
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (idx_wr) begin
      idx   <= new_idx;
      phase <= PH_RED;
    end else if (data_wr) begin
      phase <= phase_after(phase);
      if (phase == PH_BLU) idx <= idx + 1'b1;
    end
  end

  assign comp_we = data_wr ? phase_onehot(phase) : 3'b000;
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        comp_we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CH_W-1:0]   wr_val,
  input  logic [IDX_W-1:0]  lk_index,
  output logic [3*CH_W-1:0] lk_rgb
);
  localparam int NUM_ENTRIES = 1 << IDX_W;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [CH_W-1:0] mem [NUM_ENTRIES];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int e = 0; e < NUM_ENTRIES; e++)
          mem[e] <= (e == NUM_ENTRIES - 1) ? {CH_W{1'b1}} : {CH_W{1'b0}};
      end else if (comp_we[c]) begin
        mem[wr_idx] <= wr_val;
      end
    end

    assign lk_rgb[(2-c)*CH_W +: CH_W] = mem[lk_index];
  end
endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int CH_W     = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int IDX_OFS  = 0,
  parameter int DATA_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IDX_W-1:0]  lk_index,
  output logic [3*CH_W-1:0] lk_rgb,
  output logic              entry_changed
);
  logic             idx_wr;
  logic             data_wr;
  logic [IDX_W-1:0] idx;
  phase_e           phase;
  logic [2:0]       comp_we;

  clut_decode #(.ADDR_W(ADDR_W), .IDX_OFS(IDX_OFS), .DATA_OFS(DATA_OFS)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .idx_wr(idx_wr), .data_wr(data_wr)
  );

  clut_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
    .new_idx(bus_wdata[DATA_W-1 -: IDX_W]),
    .idx(idx), .phase(phase), .comp_we(comp_we)
  );

  clut_store #(.IDX_W(IDX_W), .CH_W(CH_W)) u_store (
    .clk(clk), .rst_n(rst_n), .comp_we(comp_we), .wr_idx(idx),
    .wr_val(bus_wdata[DATA_W-1 -: CH_W]),
    .lk_index(lk_index), .lk_rgb(lk_rgb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) entry_changed <= 1'b0;
    else        entry_changed <= data_wr;
  end

  assign bus_rdata = '0;
endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int CH_W   = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [IDX_W-1:0]  lk_index,
  input logic [3*CH_W-1:0] lk_rgb,
  input logic              entry_changed,
  input logic              idx_wr,
  input logic              data_wr,
  input logic [IDX_W-1:0]  idx,
  input phase_e            phase,
  input logic [2:0]        comp_we
);
  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx == $past(bus_wdata[DATA_W-1 -: IDX_W])) && (phase == PH_RED)); // R2

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !idx_wr && phase != PH_BLU) |=> (phase != $past(phase)) && $stable(idx)); // R3

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |-> $onehot(comp_we)); // R3

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !idx_wr && phase == PH_BLU) |=>
      (idx == IDX_W'($past(idx) + 1'b1)) && (phase == PH_RED)); // R4

  AST_NO_SIDE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && !data_wr) |=> $stable(idx) && $stable(phase)); // R6

  AST_RED_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && phase == PH_RED && lk_index == idx) ##1 (lk_index == $past(lk_index))
      |-> lk_rgb[3*CH_W-1 -: CH_W] == $past(bus_wdata[DATA_W-1 -: CH_W])); // R7

  AST_PULSE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> entry_changed); // R8

  AST_PULSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> !entry_changed); // R8
endmodule

bind clut_loader clut_loader_chk #(.IDX_W(IDX_W), .CH_W(CH_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .lk_index(lk_index),
  .lk_rgb(lk_rgb), .entry_changed(entry_changed), .idx_wr(idx_wr),
  .data_wr(data_wr), .idx(idx), .phase(phase), .comp_we(comp_we)
);

// File: tb/tb_clut_loader.sv
`timescale 1ns/1ps
module tb_clut_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  lk_index = '0;
  logic [23:0] lk_rgb;
  logic        entry_changed;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // behavioural reference
  int ref_pal [256];
  int ref_idx;
  int ref_ph;
  bit exp_chg;

  always #5 clk = ~clk;

  clut_loader dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lk_index(lk_index), .lk_rgb(lk_rgb), .entry_changed(entry_changed)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 256; e++) ref_pal[e] = (e == 255) ? 32'hFFFFFF : 0;
      ref_idx = 0;
      ref_ph  = 0;
      exp_chg = 1'b0;
    end else begin
      exp_chg = bus_valid && bus_write && bus_addr == 4'h4;
      if (bus_valid && bus_write && bus_addr == 4'h0) begin
        ref_idx = int'(bus_wdata[31:24]);
        ref_ph  = 0;
      end else if (exp_chg) begin
        // red lives at bit 16, green at 8, blue at 0
        ref_pal[ref_idx] = (ref_pal[ref_idx] & ~(32'hFF << (16 - 8*ref_ph)))
                         | (int'(bus_wdata[31:24]) << (16 - 8*ref_ph));
        if (ref_ph == 2) begin
          ref_ph  = 0;
          ref_idx = (ref_idx + 1) % 256;
        end else begin
          ref_ph = ref_ph + 1;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (lk_rgb !== ref_pal[lk_index][23:0]) begin
        errors++;
        $display("FAIL %s lookup[%0d] actual %06h expected %06h",
                 cur_req, lk_index, lk_rgb, ref_pal[lk_index][23:0]);
      end
      checks++;
      if (entry_changed !== exp_chg) begin
        errors++;
        $display("FAIL R8 entry_changed actual %0b expected %0b", entry_changed, exp_chg);
      end
      checks++;
      if (bus_rdata !== 32'h0) begin
        errors++;
        $display("FAIL R5 rdata actual %08h expected 00000000", bus_rdata);
      end
    end
  end

  task automatic idle();
    @(negedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic xfer(input bit wr, input logic [3:0] a, input logic [7:0] top);
    @(negedge clk); #1;
    bus_valid = 1'b1; bus_write = wr; bus_addr = a;
    bus_wdata = {top, 24'h5A3C96};
  endtask

  task automatic look(input logic [7:0] i);
    lk_index = i;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1: reset contents, swept over every entry
    cur_req = "R1";
    for (int e = 0; e < 256; e++) begin @(negedge clk); #1; look(8'(e)); end
    // R1: first data write lands in red of entry 0
    look(8'd0);
    xfer(1, 4'h4, 8'h11); idle();
    look(8'd255);
    xfer(1, 4'h4, 8'h22); xfer(1, 4'h4, 8'h33); idle(); look(8'd0); idle();

    // R2/R3: explicit index, full triple
    cur_req = "R2/R3";
    xfer(1, 4'h0, 8'h40); look(8'h40);
    xfer(1, 4'h4, 8'hA1); xfer(1, 4'h4, 8'hB2); xfer(1, 4'h4, 8'hC3);
    idle(); idle(); look(8'h41);
    xfer(1, 4'h4, 8'h01); idle(); idle();

    // R4/R7: wrap 255 -> 0 with lookup parked on the written entry
    cur_req = "R4/R7";
    xfer(1, 4'h0, 8'hFF); look(8'hFF);
    xfer(1, 4'h4, 8'h10); xfer(1, 4'h4, 8'h20); xfer(1, 4'h4, 8'h30);
    look(8'h00);
    xfer(1, 4'h4, 8'h77); xfer(1, 4'h4, 8'h88); idle(); idle();

    // R9: re-target mid-triple
    cur_req = "R9";
    xfer(1, 4'h0, 8'h80); look(8'h80);
    xfer(1, 4'h4, 8'hDE); xfer(1, 4'h4, 8'hAD);
    xfer(1, 4'h0, 8'h90); look(8'h90);
    xfer(1, 4'h4, 8'hBE); idle(); look(8'h80); idle(); idle();

    // R5/R6: reads and stray offsets leave state untouched
    cur_req = "R5/R6";
    xfer(1, 4'h0, 8'h20); look(8'h20);
    xfer(1, 4'h4, 8'h55);
    for (int a = 0; a < 16; a++) begin
      xfer(0, 4'(a), 8'hEE);
      if (a != 0 && a != 4) xfer(1, 4'(a), 8'hEE);
    end
    xfer(1, 4'h4, 8'h66); xfer(1, 4'h4, 8'h77); idle(); idle();

    // random mix of everything
    cur_req = "R3/R7";
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      look(8'($urandom_range(0, 255)));
      if (r < 5)       xfer(1, 4'h4, 8'($urandom));
      else if (r == 5) xfer(1, 4'h0, 8'($urandom));
      else if (r == 6) xfer(1, 4'($urandom), 8'($urandom));
      else if (r == 7) xfer(0, 4'($urandom), 8'($urandom));
      else             idle();
    end
    idle(); idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule